// File: doc/BRIEF.md
# H-Bridge PWM Steering Controller

This block turns one free-running period counter into the two control inputs of a two-input H-bridge driver. Software-facing control is three plain pins: a duty-cycle value, a direction bit and a coast/brake bit. In either direction one bridge input carries the pulse waveform. The other sits at a constant level, and that level picks how the motor behaves in the off phase. Flipping the direction bit swaps the roles of the two outputs.

Late in every period the block raises a one-clock pulse on `sample_go`. An external differential ADC uses this pulse to begin a back-EMF reading across the motor. The drive phase is clamped so that it always ends before this point. As a result, both bridge inputs rest at the static level while the measurement runs.

Duty, direction and mode are captured only when the counter wraps. Each period is therefore built from one consistent setting. All pins are plain control or status signals, with no handshakes. An update that arrives during a period waits for the next boundary.

Top module: `hbr_drive`

## Requirements
- R1: The counter runs from 0 to PERIOD-1 and wraps. `sample_go` is high exactly when the count equals TRIG_AT = floor(PERIOD*95/100). The first pulse therefore comes TRIG_AT clocks after reset release, and later pulses follow every PERIOD clocks.
- R2: `sample_go` is one clock wide and is never high on two consecutive cycles.
- R3: When the captured direction is 0, `out_a` is the modulated output and `out_b` is static. When it is 1, `out_b` is modulated and `out_a` is static.
- R4: With mode 0 (coast), the static output is low. The modulated output is high while the count is below the captured duty, and low for the rest of the period.
- R5: With mode 1 (brake), the static output is high. The modulated output is low while the count is below the captured duty, and high for the rest of the period.
- R6: A captured duty of 0 gives no drive phase, so both outputs stay at the static level for the whole period.
- R7: A duty of TRIG_AT or more is clamped to TRIG_AT. Both outputs are at the static level from the trigger count to the end of the period.
- R8: Duty, direction and mode are sampled only on the clock edge where the count goes from PERIOD-1 to 0. Changes at any other time do not affect the current period.
- R9: Asynchronous active-low reset clears the count to 0 and the captured settings to duty 0, direction 0, coast. Both outputs and `sample_go` are low during reset. The first period after release uses these cleared settings, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty | input | CNT_W | Drive-phase length in counts, captured at wrap |
| dir | input | 1 | Direction: selects which output is modulated |
| brake | input | 1 | Mode: 0 coast, 1 brake |
| out_a | output | 1 | First bridge input |
| out_b | output | 1 | Second bridge input |
| sample_go | output | 1 | One-clock ADC start pulse at the trigger count |

## Verification
The hardest case to reach is a settings change that arrives in the middle of a period, because its effect is deliberately delayed and a wrong design only fails on the next boundary. The stimulus therefore holds a known setting, changes every input at an arbitrary count inside the period, and checks each remaining count against the old setting. It then checks the full following period against the new one. A reset applied mid-period is handled the same way: the run restarts its count model from zero and confirms that the first period uses the cleared settings.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  // Per-output drive selection
  typedef enum logic [1:0] {
    DRV_LOW     = 2'd0,
    DRV_HIGH    = 2'd1,
    DRV_PWM     = 2'd2,
    DRV_PWM_INV = 2'd3
  } drv_mode_e;

  // Captured steering settings
  typedef struct packed {
    logic dir;
    logic brake;
  } steer_cfg_t;

  // Trigger count as a fraction of the period
  function automatic int trig_count(input int period);
    return (period * 95) / 100;
  endfunction

endpackage

// File: rtl/hbr_period_ctr.sv
module hbr_period_ctr #(
  parameter int CNT_W  = 16,
  parameter int PERIOD = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbr_shadow.sv
module hbr_shadow
  import hbr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LIMIT = 95
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [CNT_W-1:0] duty_in,
  input  logic             dir_in,
  input  logic             brake_in,
  output logic [CNT_W-1:0] duty_q,
  output steer_cfg_t       cfg_q
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] duty_clamped;

  // Drive phase never runs into the sampling window
  assign duty_clamped = (duty_in > LIM) ? LIM : duty_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q      <= '0;
      cfg_q.dir   <= 1'b0;
      cfg_q.brake <= 1'b0;
    end else if (wrap) begin
      duty_q      <= duty_clamped;
      cfg_q.dir   <= dir_in;
      cfg_q.brake <= brake_in;
    end
  end
endmodule

// File: rtl/hbr_compare.sv
module hbr_compare #(
  parameter int CNT_W   = 16,
  parameter int TRIG_AT = 95
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_q,
  output logic             active,
  output logic             trig
);
  localparam logic [CNT_W-1:0] TRIG_CNT = CNT_W'(TRIG_AT);

  assign active = (cnt < duty_q);
  assign trig   = (cnt == TRIG_CNT);
endmodule

// File: rtl/hbr_steer.sv
module hbr_steer
  import hbr_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  steer_cfg_t       cfg,
  input  logic             active,
  output logic [N_OUT-1:0] drv
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    drv_mode_e mode;
    logic      modulated;

    assign modulated = (32'(cfg.dir) == i);

    always_comb begin
      if (modulated) begin
        mode = cfg.brake ? DRV_PWM_INV : DRV_PWM;
      end else begin
        mode = cfg.brake ? DRV_HIGH : DRV_LOW;
      end
    end

    always_comb begin
      unique case (mode)
        DRV_LOW:     drv[i] = 1'b0;
        DRV_HIGH:    drv[i] = 1'b1;
        DRV_PWM:     drv[i] = active;
        DRV_PWM_INV: drv[i] = ~active;
        default:     drv[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/hbr_drive.sv
module hbr_drive
  import hbr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PERIOD = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty,
  input  logic             dir,
  input  logic             brake,
  output logic             out_a,
  output logic             out_b,
  output logic             sample_go
);
  localparam int TRIG_AT = trig_count(PERIOD);

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CNT_W-1:0] duty_q;
  steer_cfg_t       cfg_q;
  logic             active;
  logic [1:0]       drv;

  hbr_period_ctr #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (cnt),
    .wrap (wrap)
  );

  hbr_shadow #(.CNT_W(CNT_W), .LIMIT(TRIG_AT)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap),
    .duty_in (duty),
    .dir_in  (dir),
    .brake_in(brake),
    .duty_q  (duty_q),
    .cfg_q   (cfg_q)
  );

  hbr_compare #(.CNT_W(CNT_W), .TRIG_AT(TRIG_AT)) u_cmp (
    .cnt   (cnt),
    .duty_q(duty_q),
    .active(active),
    .trig  (sample_go)
  );

  hbr_steer #(.N_OUT(2)) u_steer (
    .cfg   (cfg_q),
    .active(active),
    .drv   (drv)
  );

  assign out_a = drv[0];
  assign out_b = drv[1];
endmodule

// File: rtl/hbr_drive_chk.sv
module hbr_drive_chk #(
  parameter int CNT_W   = 16,
  parameter int TRIG_AT = 95
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic [CNT_W-1:0] duty_q,
  input logic             dir_q,
  input logic             brake_q,
  input logic             out_a,
  input logic             out_b,
  input logic             sample_go
);
  localparam logic [CNT_W-1:0] TRIG_CNT = CNT_W'(TRIG_AT);

  // R1: pulse lands on the trigger count
  a_r1_trig_at_count: assert property (@(posedge clk) disable iff (!rst_n)
    sample_go |-> (cnt == TRIG_CNT));

  // R2: never two pulses back to back
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sample_go |=> !sample_go);

  // R3: the unmodulated side holds the mode level
  a_r3_static_side: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q ? out_a : out_b) == brake_q);

  // R6: zero duty keeps both outputs idle
  a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> (out_a == brake_q && out_b == brake_q));

  // R7: holdoff from the trigger count onward
  a_r7_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= TRIG_CNT) |-> (out_a == brake_q && out_b == brake_q));

  // R8: captured settings move only at the wrap
  a_r8_hold_midcycle: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(duty_q) && $stable(dir_q) && $stable(brake_q)));

  // R9: state is cleared on leaving reset
  a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt == '0 && duty_q == '0 && !out_a && !out_b));
endmodule

bind hbr_drive hbr_drive_chk #(.CNT_W(CNT_W), .TRIG_AT(TRIG_AT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (cnt),
  .wrap     (wrap),
  .duty_q   (duty_q),
  .dir_q    (cfg_q.dir),
  .brake_q  (cfg_q.brake),
  .out_a    (out_a),
  .out_b    (out_b),
  .sample_go(sample_go)
);

// File: tb/hbr_drive_test.sv
`timescale 1ns/1ps
module hbr_drive_test;
  localparam int PER  = 100;
  localparam int TRIG = (PER * 95) / 100;
  localparam int NVEC = 10;

  // {duty[15:0], dir, brake}
  localparam logic [17:0] VEC [NVEC] = '{
    {16'd30,  1'b0, 1'b0},
    {16'd30,  1'b1, 1'b0},
    {16'd30,  1'b0, 1'b1},
    {16'd30,  1'b1, 1'b1},
    {16'd0,   1'b0, 1'b0},
    {16'd0,   1'b1, 1'b1},
    {16'd95,  1'b0, 1'b0},
    {16'd200, 1'b1, 1'b1},
    {16'd1,   1'b0, 1'b0},
    {16'd94,  1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] duty;
  logic        dir;
  logic        brake;
  logic        out_a, out_b, sample_go;

  int total = 0;
  int bad   = 0;
  int p     = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  hbr_drive #(.CNT_W(16), .PERIOD(PER)) uut (
    .clk(clk), .rst_n(rst_n), .duty(duty), .dir(dir), .brake(brake),
    .out_a(out_a), .out_b(out_b), .sample_go(sample_go)
  );

  function automatic logic [2:0] model(int pc, int d, logic dr, logic bk);
    int   dc;
    logic act, md, a, b;
    dc  = (d > TRIG) ? TRIG : d;
    act = (pc < dc);
    md  = bk ? ~act : act;
    a   = dr ? bk : md;
    b   = dr ? md : bk;
    return {a, b, (pc == TRIG)};
  endfunction

  task automatic step();
    @(posedge clk);
    p = (rst_n) ? (p + 1) % PER : 0;
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s count=%0d got={a,b,go}=%b expected=%b", tag, p, got, exp);
    end
  endtask

  // Check one full period that uses the given captured settings
  task automatic check_period(string tag, int d, logic dr, logic bk);
    for (int k = 0; k < PER; k++) begin
      chk(tag, {out_a, out_b, sample_go}, model(p, d, dr, bk));
      step();
    end
  endtask

  task automatic run_vec(string tag, int d, logic dr, logic bk);
    duty = 16'(d); dir = dr; brake = bk;
    do step(); while (p != 0);
    check_period(tag, d, dr, bk);
  endtask

  function automatic string tag_for(int d, logic bk);
    if (d == 0)         return "R6 R3";
    else if (d >= TRIG) return "R7 R3 R1 R2";
    else if (bk)        return "R5 R3 R1";
    else                return "R4 R3 R2";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; duty = 16'd50; dir = 1'b1; brake = 1'b1;
    repeat (3) @(negedge clk);
    // R9: outputs quiet during reset
    chk("R9 reset", {out_a, out_b, sample_go}, 3'b000);
    rst_n = 1'b1; p = 0;
    // R9: first period uses cleared settings, inputs ignored; R1 first pulse
    check_period("R9 first period", 0, 1'b0, 1'b0);
    // R8: inputs held since reset get captured at the first wrap
    check_period("R8 first capture", 50, 1'b1, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      int   d;
      logic dr, bk;
      d  = int'(VEC[i][17:2]);
      dr = VEC[i][1];
      bk = VEC[i][0];
      run_vec(tag_for(d, bk), d, dr, bk);
    end

    // R8: mid-period change waits for the next wrap (last vector is 94/1/0)
    repeat (10) step();
    duty = 16'd20; dir = 1'b0; brake = 1'b1;
    while (p != 0) begin
      chk("R8 mid-period hold", {out_a, out_b, sample_go}, model(p, 94, 1'b1, 1'b0));
      step();
    end
    check_period("R8 applied at wrap", 20, 1'b0, 1'b1);

    // R9: reset in the middle of a period
    repeat (40) step();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid-run reset", {out_a, out_b, sample_go}, 3'b000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1; p = 0;
    check_period("R9 restart R1", 0, 1'b0, 1'b0);
    check_period("R9 recapture", 20, 1'b0, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule